// File: doc/BRIEF.md
# Vector Inverted-Immediate Move Unit

This block takes one 32-bit instruction word per clock, qualified by a valid flag, and recognises a single vector instruction: move an inverted immediate into every element of a vector register. For a recognised word it builds a 64-bit pattern from the 8-bit immediate. The pattern's shape depends on a 4-bit mode field, which picks 16-bit elements with a shift, 32-bit elements with a shift, or 32-bit elements with a shift that fills the vacated low bits with ones. The pattern is repeated to 64 or 128 bits and then complemented. The result is written into one of 32 vector registers, each 128 bits wide.

Recognised words write on the next clock edge. Any other valid word raises an undefined indication for one cycle and leaves the register file alone. A combinational read port lets the surrounding logic, or a bench, look at any register at any time.

Top module: `vinv_imm_unit`

## Requirements
- R1: A valid word is recognised only when bit 31 is 0, bit 29 is 1, bits 28..19 equal 0111100000, bit 11 is 0, bit 10 is 1, and the mode field (bits 15..12) holds one of the accepted patterns. Bit 30 selects the width and bits 4..0 name the destination register.
- R2: The 8-bit immediate is formed as {bits 18..16, bits 9..5}, with bit 18 as its most significant bit.
- R3: Mode 10x0 gives 16-bit elements holding the immediate shifted left by 8 when mode bit 1 is 1, and by 0 when it is 0.
- R4: Mode 0xx0 gives 32-bit elements holding the immediate shifted left by 8 times mode bits 2..1 (0, 8, 16 or 24).
- R5: Mode 110x gives 32-bit elements holding the immediate shifted left by 8 (mode bit 0 = 0) or by 16 (mode bit 0 = 1), with the vacated low bits set to 1.
- R6: When bit 30 is 1 the 64-bit pattern is repeated across all 128 bits. When bit 30 is 0 it fills bits 63..0 and bits 127..64 are written as zero.
- R7: The value written to the low 64 bits (or all 128 bits) is the bitwise complement of the repeated pattern.
- R8: Mode values 0001, 0011, 0101, 0111, 1001, 1011, 1110 and 1111 are not recognised. A valid word carrying one of them raises undef_flag in the next cycle and writes nothing.
- R9: A valid word with any fixed bit wrong raises undef_flag in the next cycle and writes nothing. A word with insn_valid low does nothing and leaves undef_flag low in the next cycle.
- R10: The write lands on the clock edge after the valid recognised word. A read of that register in the following cycle returns the new value, and a second write to the same register on the next edge replaces it.
- R11: With rst_n low at a clock edge (synchronous, active low), all 32 registers become zero and undef_flag becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| insn_valid | input | 1 | insn_word carries a word this cycle |
| insn_word | input | 32 | Instruction word |
| rd_addr | input | 5 | Read port register index |
| rd_data | output | 128 | Combinational contents of register rd_addr |
| undef_flag | output | 1 | High for one cycle after a valid word that was not recognised |

## Verification
A bad expansion or a wrong inversion shows up on rd_data one cycle after the word, when the destination is read back. A wrong shift, fill, lane or upper-half value appears directly as wrong bits in the read data. A decode fault shows in the same cycle as either a spurious undef_flag or a missing one. It can also show as a change to a register that should have stayed the same, which becomes visible as soon as that register is read. Any register that was corrupted without being the target stays wrong until it is overwritten, so a full read sweep after reset and after the run exposes it.

// File: rtl/vim_pkg.sv
package vim_pkg;

  localparam int INSN_W = 32;
  localparam int PAT_W  = 64;
  localparam int VLEN   = 128;
  localparam int DST_W  = 5;

  typedef enum logic [1:0] {
    FORM_NONE,
    FORM_H16,
    FORM_W32,
    FORM_W32_ONES
  } imm_form_e;

  typedef struct packed {
    logic            hit;
    imm_form_e       form;
    logic            wide;
    logic [3:0]      mode;
    logic [7:0]      imm8;
    logic [DST_W-1:0] dst;
  } dec_t;

  // Classify the 4-bit mode field into an immediate form.
  function automatic imm_form_e classify_mode(input logic [3:0] m);
    imm_form_e f;
    f = FORM_NONE;
    if (m[3:2] == 2'b10 && !m[0])   f = FORM_H16;
    else if (!m[3] && !m[0])        f = FORM_W32;
    else if (m[3:1] == 3'b110)      f = FORM_W32_ONES;
    return f;
  endfunction

  // Build the 64-bit pattern (before inversion) for a form.
  function automatic logic [PAT_W-1:0] expand_pat(input imm_form_e f,
                                                  input logic [3:0] m,
                                                  input logic [7:0] v);
    logic [15:0] h;
    logic [31:0] w;
    logic [PAT_W-1:0] p;
    h = '0;
    w = '0;
    p = '0;
    case (f)
      FORM_H16: begin
        h = m[1] ? {v, 8'h00} : {8'h00, v};
        p = {4{h}};
      end
      FORM_W32: begin
        case (m[2:1])
          2'd0:    w = {24'h0, v};
          2'd1:    w = {16'h0, v, 8'h0};
          2'd2:    w = {8'h0, v, 16'h0};
          default: w = {v, 24'h0};
        endcase
        p = {2{w}};
      end
      FORM_W32_ONES: begin
        w = m[0] ? {8'h0, v, 16'hFFFF} : {16'h0, v, 8'hFF};
        p = {2{w}};
      end
      default: p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/vim_decode.sv
module vim_decode
  import vim_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output dec_t              dec
);
  localparam logic [9:0] OPC_MID = 10'b0111100000;

  logic fixed_ok;
  imm_form_e form;

  assign fixed_ok = !word[31] && word[29] && (word[28:19] == OPC_MID)
                    && !word[11] && word[10];
  assign form = classify_mode(word[15:12]);

  always_comb begin
    dec.mode = word[15:12];
    dec.imm8 = {word[18:16], word[9:5]};
    dec.wide = word[30];
    dec.dst  = word[DST_W-1:0];
    dec.form = form;
    dec.hit  = fixed_ok && (form != FORM_NONE);
  end
endmodule

// File: rtl/vim_expand.sv
module vim_expand
  import vim_pkg::*;
#(
  parameter int OUT_W = VLEN
) (
  input  dec_t             dec,
  output logic [OUT_W-1:0] result
);
  localparam int LANES = OUT_W / PAT_W;

  logic [PAT_W-1:0] inv_pat;

  assign inv_pat = ~expand_pat(dec.form, dec.mode, dec.imm8);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_base
      assign result[PAT_W-1:0] = inv_pat;
    end else begin : g_upper
      assign result[l*PAT_W +: PAT_W] = dec.wide ? inv_pat : '0;
    end
  end
endmodule

// File: rtl/vim_regfile.sv
module vim_regfile #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                            mem[i] <= '0;
      else if (we && (waddr == AW'(i)))      mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/vinv_imm_unit.sv
module vinv_imm_unit
  import vim_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [INSN_W-1:0] insn_word,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [VLEN-1:0]   rd_data,
  output logic              undef_flag
);
  dec_t              dec;
  logic              is_match;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_idx;
  logic [VLEN-1:0]   wr_data;
  logic              undef_q;

  vim_decode u_dec (
    .word (insn_word),
    .dec  (dec)
  );

  vim_expand #(.OUT_W(VLEN)) u_exp (
    .dec    (dec),
    .result (wr_data)
  );

  assign is_match = dec.hit;
  assign wr_en    = insn_valid && is_match;
  assign wr_idx   = dec.dst[ADDR_W-1:0];

  vim_regfile #(.DEPTH(NUM_REGS), .WIDTH(VLEN)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wr_idx),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) undef_q <= 1'b0;
    else        undef_q <= insn_valid && !is_match;
  end

  assign undef_flag = undef_q;
endmodule

// File: rtl/vim_checker.sv
module vim_checker #(
  parameter int AW = 5,
  parameter int DW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          insn_valid,
  input logic [31:0]   insn_word,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data,
  input logic          undef_flag
);
  AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> insn_valid); // R9

  AST_WRITE_NO_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !undef_flag); // R8

  AST_IDLE_NO_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> !undef_flag); // R9

  AST_REJECT_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !wr_en) |=> undef_flag); // R8

  AST_ODD_MODE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_word[12] && (insn_word[15:13] != 3'b110)) |-> !wr_en); // R8

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !insn_word[30]) |-> (wr_data[DW-1:64] == '0)); // R6

  AST_ONES_FILL_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (insn_word[15:13] == 3'b110)) |-> (wr_data[7:0] == 8'h00)); // R5

  AST_HALF_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (insn_word[15:14] == 2'b10)) |-> (wr_data[15:0] == wr_data[31:16])); // R3

  AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_addr != $past(insn_word[AW-1:0])) || (rd_data == $past(wr_data)))); // R10
endmodule

bind vinv_imm_unit vim_checker #(.AW(ADDR_W), .DW(vim_pkg::VLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_valid (insn_valid),
  .insn_word  (insn_word),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .undef_flag (undef_flag)
);

// File: tb/tb_vinv_imm_unit.sv
module tb_vinv_imm_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         insn_valid = 1'b0;
  logic [31:0]  insn_word = '0;
  logic [4:0]   rd_addr = '0;
  logic [127:0] rd_data;
  logic         undef_flag;

  vinv_imm_unit dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .rd_addr(rd_addr), .rd_data(rd_data), .undef_flag(undef_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  string cur_req  = "R11";
  string req_q    = "R11";

  logic [127:0] model [32];
  bit           exp_undef = 0;

  // Reference: pattern for one word, element-wise and bit by bit.
  function automatic logic [127:0] ref_value(input bit q, input bit [3:0] m,
                                             input bit [7:0] v, output bit ok);
    int esz, sh;
    bit fill;
    longint unsigned elem;
    logic [127:0] r;
    ok = 1; fill = 0; esz = 32; sh = 0;
    if (m[3:2] == 2'b10 && m[0] == 1'b0)      begin esz = 16; sh = m[1] ? 8 : 0; end
    else if (m[3] == 1'b0 && m[0] == 1'b0)    begin esz = 32; sh = 8 * int'(m[2:1]); end
    else if (m[3:1] == 3'b110)                begin esz = 32; sh = m[0] ? 16 : 8; fill = 1; end
    else ok = 0;
    elem = longint'(v) << sh;
    if (fill) elem = elem | ((64'd1 << sh) - 64'd1);
    r = '0;
    for (int b = 0; b < (q ? 128 : 64); b++) r[b] = ~elem[b % esz];
    return r;
  endfunction

  function automatic logic [31:0] mk(input bit q, input bit [3:0] m,
                                     input bit [7:0] v, input bit [4:0] rd);
    return {1'b0, q, 1'b1, 10'b0111100000, v[7:5], m, 1'b0, 1'b1, v[4:0], rd};
  endfunction

  // Model update at each edge, from the inputs held since the last edge.
  always @(posedge clk) begin
    bit ok;
    bit fixed;
    logic [127:0] val;
    req_q = cur_req;
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) model[i] = '0;
      exp_undef = 0;
    end else if (insn_valid) begin
      fixed = (insn_word[31] == 0) && insn_word[29] && (insn_word[28:19] == 10'b0111100000)
              && (insn_word[11] == 0) && insn_word[10];
      val = ref_value(insn_word[30], insn_word[15:12],
                      {insn_word[18:16], insn_word[9:5]}, ok);
      if (fixed && ok) begin
        model[insn_word[4:0]] = val;
        exp_undef = 0;
      end else begin
        exp_undef = 1;
      end
    end else begin
      exp_undef = 0;
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n || $time > CLK_PERIOD) begin
      n_checks++;
      if (rd_data !== model[rd_addr]) begin
        n_fail++;
        $display("FAIL %s reg %0d data actual=%h expected=%h", req_q, rd_addr,
                 rd_data, model[rd_addr]);
      end
      n_checks++;
      if (undef_flag !== exp_undef) begin
        n_fail++;
        $display("FAIL %s undef_flag actual=%b expected=%b", req_q, undef_flag, exp_undef);
      end
    end
  end

  task automatic step(input bit v, input logic [31:0] w, input logic [4:0] ra, input string tag);
    @(posedge clk); #1;
    insn_valid = v; insn_word = w; rd_addr = ra; cur_req = tag;
  endtask

  // One word, then an idle cycle reading its destination back.
  task automatic issue(input bit v, input logic [31:0] w, input string tag);
    step(v, w, w[4:0], tag);
    step(0, w, w[4:0], tag);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 32; i++) step(0, 32'h0, 5'(i), tag);
  endtask

  task automatic do_reset;
    @(posedge clk); #1; rst_n = 0; insn_valid = 0; cur_req = "R11";
    repeat (2) @(posedge clk);
    #1; rst_n = 1;
  endtask

  initial begin
    logic [15:0] lfsr;
    logic [31:0] w;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    sweep("R11");

    // Every mode, both widths (R3 R4 R5 R6 R7 R8)
    for (int m = 0; m < 16; m++) begin
      for (int q = 0; q < 2; q++) begin
        string tag;
        case (m)
          8, 10: tag = "R3";
          0, 2, 4, 6: tag = "R4";
          12, 13: tag = "R5";
          default: tag = "R8";
        endcase
        issue(1, mk(q[0], 4'(m), 8'(8'hA5 ^ (m * 17)), 5'(m * 2 + q)), tag);
      end
    end
    issue(1, mk(1, 4'h0, 8'h00, 5'd1), "R7");
    issue(1, mk(0, 4'h0, 8'hFF, 5'd2), "R6");
    issue(1, mk(1, 4'h6, 8'b1000_0001, 5'd3), "R2");
    issue(1, mk(1, 4'hD, 8'b0110_0000, 5'd4), "R2");
    issue(1, mk(0, 4'hC, 8'h7E, 5'd5), "R5");

    // Fixed-bit faults target a written register (R1 R9)
    issue(1, mk(1, 4'h2, 8'h3C, 5'd9), "R1");
    issue(1, mk(1, 4'h2, 8'h11, 5'd9) | 32'h8000_0000, "R9");
    issue(1, mk(1, 4'h2, 8'h11, 5'd9) & ~32'h2000_0000, "R9");
    issue(1, mk(1, 4'h2, 8'h11, 5'd9) | 32'h0000_0800, "R9");
    issue(1, mk(1, 4'h2, 8'h11, 5'd9) & ~32'h0000_0400, "R9");
    for (int b = 19; b < 29; b++) issue(1, mk(1, 4'h2, 8'h11, 5'd9) ^ (32'h1 << b), "R1");
    issue(0, mk(1, 4'h4, 8'h22, 5'd9), "R9");

    // Back-to-back writes (R10)
    step(1, mk(1, 4'h8, 8'h12, 5'd20), 5'd20, "R10");
    step(1, mk(0, 4'hA, 8'h34, 5'd20), 5'd20, "R10");
    step(1, mk(1, 4'h6, 8'h56, 5'd21), 5'd20, "R10");
    step(1, mk(1, 4'hF, 8'h78, 5'd20), 5'd21, "R10");
    step(0, 32'h0, 5'd20, "R10");

    // Pseudo-random words
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      w = mk(lfsr[0], lfsr[4:1], lfsr[12:5], 5'(lfsr[15:11] ^ 5'(k)));
      if (lfsr[14:13] == 2'b00) w = w ^ (32'h1 << lfsr[9:5]);
      step(lfsr[15] | lfsr[3], w, 5'(k), "R10");
    end
    sweep("R7");

    do_reset;
    sweep("R11");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule